// File: doc/BRIEF.md
# Shadow-Buffered Up/Down PWM Channel

This block is a single pulse-width-modulation channel built around a 16-bit counter. The counter steps on every clock, or on every 64th clock when the slow input rate is chosen. It runs only while the run bit is set. Two compare values, a period and a pulse width, are written through a small register port. The hardware never compares against the written values directly. It uses a shadow copy of each, and these copies reload only when a new PWM cycle begins. While the timer is stopped, a write goes straight through to its shadow copy.

Two counting schemes are offered. In edge-aligned operation the counter climbs to the period and wraps to zero. In centre-aligned operation it climbs to the period, turns around, and descends to zero before climbing again. For the same period value, the centre-aligned cycle is about twice as long. The output is high while the counter is at or above the width shadow. The counter value and its direction are also brought out, so that a neighbouring block can observe the phase of the PWM cycle.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the counter is 0, the direction is up (`cnt_down_o`=0), `pwm_out` is 0, and the period, width and control registers hold 0.
- R2: While the run bit is 0, `cnt_o`, `cnt_down_o` and `pwm_out` hold their values on every clock.
- R3: With run=1 and slow=0, the counter takes one step on every clock edge.
- R4: With run=1 and slow=1, the counter takes one step every 64 clocks. The first step comes on the 64th edge after the edge that set the run bit.
- R5: In edge-aligned mode (centre=0), a step taken with the counter at or above the period shadow sets the counter to 0. Otherwise the step adds one, so a cycle lasts period+1 steps.
- R6: In centre-aligned mode (centre=1), the counter counts up until it reaches the period shadow, then counts down until it reaches 0, then counts up again (from 0 the next step goes to 1), so a cycle lasts 2×period steps. With a period shadow of 0 the counter stays at 0 and the direction stays up.
- R7: While running, `pwm_out` on each edge takes the value (counter ≥ width shadow) evaluated just before that edge.
- R8: While running, a write to the period or width register leaves the comparison unchanged until a new cycle starts. A cycle starts at the wrap to 0 in edge mode, or at the down-to-up turn at 0 in centre mode. Both shadows reload on the clock after that step.
- R9: While the run bit is 0, a period or width write reaches the shadow copy on the same edge.
- R10: The write port uses `wr_sel` 0 for period, 1 for width and 2 for control. In the control word, bit 0 is run, bit 1 is slow (divide by 64) and bit 2 is centre mode. A write with `wr_sel`=3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 period, 1 width, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | PWM output |
| cnt_o | output | 16 | Current counter value |
| cnt_down_o | output | 1 | 1 while the counter counts down |

## Verification
A counter step appears on `cnt_o` one clock after its tick. `pwm_out` follows the counter by one more clock. A shadow reload takes effect one clock after the step that starts a new cycle. A write made while the timer is stopped reaches the shadow on the write edge itself. With the slow rate, the first step lands 64 edges after the run bit is set. The bench carries a behavioural model that applies these same latencies edge by edge and compares all three outputs on every falling edge. Directed checks also measure extremes, duty counts and step spacing over windows. Each window starts only at a falling edge that follows the stimulus, so that every register on the path has settled.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
   typedef enum logic [1:0] {
      SEL_PERIOD = 2'd0,
      SEL_WIDTH  = 2'd1,
      SEL_CTRL   = 2'd2,
      SEL_NONE   = 2'd3
   } pwm_sel_e;

   // control word layout: bit 2 centre, bit 1 slow, bit 0 run
   typedef struct packed {
      logic centre;
      logic slow;
      logic run;
   } pwm_ctl_t;

   localparam int CTL_W = 3;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
   parameter int DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic slow_i,
   output logic tick_o
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 1) begin : g_bad_div
         $error("pwm_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_nodiv
         assign tick_o = run_i;
      end else begin : g_div
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pre_q <= '0;
            else if (!run_i)
               pre_q <= '0;
            else if (pre_q == PW'(DIV - 1))
               pre_q <= '0;
            else
               pre_q <= pre_q + 1'b1;
         end
         assign tick_o = run_i & (~slow_i | (pre_q == PW'(DIV - 1)));
      end
   endgenerate
endmodule

// File: rtl/pwm_shadow_reg.sv
module pwm_shadow_reg #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   input  logic         stopped_i,
   input  logic         reload_i,
   output logic [W-1:0] sh_o
);
   logic [W-1:0] cpu_q;
   logic [W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cpu_q <= '0;
      else if (wr_i)
         cpu_q <= data_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_q <= '0;
      else if (wr_i && stopped_i)
         sh_q <= data_i;
      else if (reload_i)
         sh_q <= cpu_q;
   end

   assign sh_o = sh_q;
endmodule

// File: rtl/pwm_updown_core.sv
module pwm_updown_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         tick_i,
   input  logic         centre_i,
   input  logic [W-1:0] per_sh_i,
   input  logic [W-1:0] wid_sh_i,
   output logic [W-1:0] cnt_o,
   output logic         down_o,
   output logic         start_o,
   output logic         pwm_o
);
   logic [W-1:0] cnt_q;
   logic         dn_q;
   logic         start_q;
   logic         pwm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         dn_q    <= 1'b0;
         start_q <= 1'b0;
         pwm_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (run_i)
            pwm_q <= (cnt_q >= wid_sh_i);
         if (tick_i) begin
            if (!centre_i) begin
               dn_q <= 1'b0;
               if (cnt_q >= per_sh_i) begin
                  cnt_q   <= '0;
                  start_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end else if (per_sh_i == '0) begin
               cnt_q   <= '0;
               dn_q    <= 1'b0;
               start_q <= 1'b1;
            end else if (dn_q) begin
               if (cnt_q == '0) begin
                  dn_q    <= 1'b0;
                  cnt_q   <= W'(1);
                  start_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end else if (cnt_q >= per_sh_i) begin
               dn_q  <= 1'b1;
               cnt_q <= cnt_q - 1'b1;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign down_o  = dn_q;
   assign start_o = start_q;
   assign pwm_o   = pwm_q;
endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
   import pwm_shadow_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int DIV   = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   output logic             pwm_out,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cnt_down_o
);
   generate
      if (CNT_W < CTL_W) begin : g_bad_width
         $error("pwm_shadow_chan: CNT_W too small for control word");
      end
   endgenerate

   pwm_ctl_t         ctl_q;
   logic             tick;
   logic             cyc_start;
   logic [CNT_W-1:0] per_sh;
   logic [CNT_W-1:0] wid_sh;
   logic             wr_per;
   logic             wr_wid;

   assign wr_per = wr_en && (pwm_sel_e'(wr_sel) == SEL_PERIOD);
   assign wr_wid = wr_en && (pwm_sel_e'(wr_sel) == SEL_WIDTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctl_q <= '0;
      else if (wr_en && (pwm_sel_e'(wr_sel) == SEL_CTRL))
         ctl_q <= pwm_ctl_t'(wr_data[CTL_W-1:0]);
   end

   pwm_prescale #(.DIV(DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (ctl_q.run),
      .slow_i (ctl_q.slow),
      .tick_o (tick)
   );

   pwm_shadow_reg #(.W(CNT_W)) u_per (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_per),
      .data_i    (wr_data),
      .stopped_i (~ctl_q.run),
      .reload_i  (cyc_start),
      .sh_o      (per_sh)
   );

   pwm_shadow_reg #(.W(CNT_W)) u_wid (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (wr_wid),
      .data_i    (wr_data),
      .stopped_i (~ctl_q.run),
      .reload_i  (cyc_start),
      .sh_o      (wid_sh)
   );

   pwm_updown_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (ctl_q.run),
      .tick_i   (tick),
      .centre_i (ctl_q.centre),
      .per_sh_i (per_sh),
      .wid_sh_i (wid_sh),
      .cnt_o    (cnt_o),
      .down_o   (cnt_down_o),
      .start_o  (cyc_start),
      .pwm_o    (pwm_out)
   );
endmodule

// File: rtl/pwm_shadow_chan_chk.sv
module pwm_shadow_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             slow,
   input logic             centre,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic             dn,
   input logic             pwm,
   input logic [CNT_W-1:0] psh,
   input logic [CNT_W-1:0] wsh,
   input logic             start
);
   a_r2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(cnt) && $stable(dn) && $stable(pwm));

   a_r4_slow_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (run && slow && !tick) |=> $stable(cnt));

   a_r3_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !slow && psh != '0) |=> !$stable(cnt));

   a_r5_edge_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !centre && cnt >= psh) |=> (cnt == '0) && start);

   a_r6_turn_down: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && centre && !dn && psh != '0 && cnt >= psh) |=> dn);

   a_r6_turn_up: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && centre && dn && cnt == '0 && psh != '0) |=> !dn && (cnt == CNT_W'(1)));

   a_r7_output: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> pwm == ($past(cnt) >= $past(wsh)));

   a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !start) |=> $stable(psh) && $stable(wsh));
endmodule

bind pwm_shadow_chan pwm_shadow_chan_chk #(.CNT_W(CNT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .run    (ctl_q.run),
   .slow   (ctl_q.slow),
   .centre (ctl_q.centre),
   .tick   (tick),
   .cnt    (cnt_o),
   .dn     (cnt_down_o),
   .pwm    (pwm_out),
   .psh    (per_sh),
   .wsh    (wid_sh),
   .start  (cyc_start)
);

// File: tb/pwm_shadow_chan_tb.sv
module pwm_shadow_chan_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        pwm_out;
   logic [15:0] cnt_o;
   logic        cnt_down_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;   // 50 MHz

   pwm_shadow_chan u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pwm_out(pwm_out), .cnt_o(cnt_o),
      .cnt_down_o(cnt_down_o)
   );

   // behavioural reference model
   int m_run, m_slow, m_ctr, m_per, m_wid, m_psh, m_wsh;
   int m_cnt, m_dn, m_pre, m_start, m_pwm;
   initial begin
      m_run = 0; m_slow = 0; m_ctr = 0; m_per = 0; m_wid = 0; m_psh = 0;
      m_wsh = 0; m_cnt = 0; m_dn = 0; m_pre = 0; m_start = 0; m_pwm = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_slow = 0; m_ctr = 0; m_per = 0; m_wid = 0; m_psh = 0;
         m_wsh = 0; m_cnt = 0; m_dn = 0; m_pre = 0; m_start = 0; m_pwm = 0;
      end else begin
         int tick, n_cnt, n_dn, n_st, n_psh, n_wsh;
         tick  = m_run && (!m_slow || m_pre == 63);
         n_cnt = m_cnt; n_dn = m_dn; n_st = 0;
         if (tick) begin
            if (!m_ctr) begin
               n_dn = 0;
               if (m_cnt >= m_psh) begin n_cnt = 0; n_st = 1; end
               else n_cnt = m_cnt + 1;
            end else if (m_psh == 0) begin
               n_cnt = 0; n_dn = 0; n_st = 1;
            end else if (m_dn) begin
               if (m_cnt == 0) begin n_dn = 0; n_cnt = 1; n_st = 1; end
               else n_cnt = m_cnt - 1;
            end else if (m_cnt >= m_psh) begin
               n_dn = 1; n_cnt = m_cnt - 1;
            end else n_cnt = m_cnt + 1;
         end
         n_psh = m_start ? m_per : m_psh;
         n_wsh = m_start ? m_wid : m_wsh;
         if (wr_en && wr_sel == 2'd0 && !m_run) n_psh = wr_data;
         if (wr_en && wr_sel == 2'd1 && !m_run) n_wsh = wr_data;
         if (m_run) m_pwm = (m_cnt >= m_wsh);
         m_pre = m_run ? (m_pre + 1) % 64 : 0;
         if (wr_en && wr_sel == 2'd0) m_per = wr_data;
         if (wr_en && wr_sel == 2'd1) m_wid = wr_data;
         if (wr_en && wr_sel == 2'd2) begin
            m_run = wr_data[0]; m_slow = wr_data[1]; m_ctr = wr_data[2];
         end
         m_cnt = n_cnt; m_dn = n_dn; m_start = n_st; m_psh = n_psh; m_wsh = n_wsh;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         check(cnt_o == m_cnt[15:0], "R3 R4 R5 R6 R8 R9 R10 counter", cnt_o, m_cnt);
         check(cnt_down_o == m_dn[0], "R6 direction", cnt_down_o, m_dn);
         check(pwm_out == m_pwm[0], "R7 output", pwm_out, m_pwm);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      int mx, mn, hi, tr, n, n2;
      logic [15:0] c0;
      logic p0, d0, dprev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cnt_o == 0, "R1 counter", cnt_o, 0);
      check(cnt_down_o == 0, "R1 direction", cnt_down_o, 0);
      check(pwm_out == 0, "R1 output", pwm_out, 0);

      // edge mode, fast, period 4 width 2 written while stopped (R9)
      wr(2'd0, 16'd4);
      wr(2'd1, 16'd2);
      wr(2'd2, 16'd1);
      repeat (10) @(negedge clk);
      mx = 0; hi = 0;
      for (int i = 0; i < 20; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         if (pwm_out) hi++;
         @(negedge clk);
      end
      check(mx == 4, "R5 edge maximum", mx, 4);
      check(hi == 12, "R7 duty count", hi, 12);
      check(hi == 12, "R9 stopped write reached shadow", hi, 12);

      // running write of period 7 (R8)
      n = 0;
      while (cnt_o != 1 && n < 50) begin @(negedge clk); n++; end
      wr(2'd0, 16'd7);
      mx = 0;
      for (int i = 0; i < 5; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         @(negedge clk);
      end
      check(mx == 4, "R8 old period kept in cycle", mx, 4);
      mx = 0;
      for (int i = 0; i < 8; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         @(negedge clk);
      end
      check(mx == 7, "R8 new period after cycle start", mx, 7);

      // stop and freeze (R2)
      wr(2'd2, 16'd0);
      c0 = cnt_o; p0 = pwm_out; d0 = cnt_down_o;
      wr(2'd1, 16'd0);   // width 0 while stopped (R9)
      repeat (10) @(negedge clk);
      check(cnt_o == c0, "R2 counter frozen", cnt_o, c0);
      check(pwm_out == p0, "R2 output frozen", pwm_out, p0);
      check(cnt_down_o == d0, "R2 direction frozen", cnt_down_o, d0);
      wr(2'd2, 16'd1);
      @(negedge clk);
      hi = 0;
      for (int i = 0; i < 16; i++) begin
         if (pwm_out) hi++;
         @(negedge clk);
      end
      check(hi == 16, "R9 width 0 gives constant high", hi, 16);

      // centre mode, period 3, width 2 (R6)
      wr(2'd2, 16'd0);
      wr(2'd0, 16'd3);
      wr(2'd1, 16'd2);
      wr(2'd2, 16'd5);
      repeat (20) @(negedge clk);
      mx = 0; mn = 100; tr = 0; dprev = cnt_down_o;
      for (int i = 0; i < 12; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         if (cnt_o < mn) mn = cnt_o;
         if (cnt_down_o != dprev) tr++;
         dprev = cnt_down_o;
         @(negedge clk);
      end
      check(mx == 3, "R6 centre maximum", mx, 3);
      check(mn == 0, "R6 centre minimum", mn, 0);
      check(tr == 4, "R6 direction turns", tr, 4);

      // slow rate, edge mode (R4)
      wr(2'd2, 16'd0);
      wr(2'd2, 16'd3);
      c0 = cnt_o; n = 0;
      while (cnt_o == c0 && n < 200) begin @(negedge clk); n++; end
      check(n == 64, "R4 first slow step", n, 64);
      c0 = cnt_o; n2 = 0;
      while (cnt_o == c0 && n2 < 200) begin @(negedge clk); n2++; end
      check(n2 == 64, "R4 slow step spacing", n2, 64);

      // fast rate step every clock (R3)
      wr(2'd2, 16'd1);
      n = 0;
      for (int i = 0; i < 8; i++) begin
         c0 = cnt_o;
         @(negedge clk);
         if (cnt_o != c0) n++;
      end
      check(n == 8, "R3 step every clock", n, 8);

      // select 3 ignored (R10)
      wr(2'd2, 16'd0);
      c0 = cnt_o;
      wr(2'd3, 16'hFFFF);
      repeat (5) @(negedge clk);
      check(cnt_o == c0, "R10 select 3 left timer stopped", cnt_o, c0);
      wr(2'd2, 16'd1);
      repeat (4) @(negedge clk);
      mx = 0;
      for (int i = 0; i < 8; i++) begin
         if (cnt_o > mx) mx = cnt_o;
         @(negedge clk);
      end
      check(mx == 3, "R10 period unchanged by select 3", mx, 3);

      // centre with period 0 (R6)
      wr(2'd2, 16'd0);
      wr(2'd0, 16'd0);
      wr(2'd2, 16'd5);
      repeat (3) @(negedge clk);
      n = 0;
      for (int i = 0; i < 5; i++) begin
         if (cnt_o == 0 && cnt_down_o == 0) n++;
         @(negedge clk);
      end
      check(n == 5, "R6 period 0 holds at 0", n, 5);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule